// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control sequencer that a small processor core uses to take an interrupt and to come back from one. It watches a single interrupt request, the current value of the global interrupt-enable bit and an instruction-boundary strobe from the execute stage. At a boundary it either starts an entry sequence or, when the execute stage has decoded a return-from-interrupt instruction, a return sequence. Both sequences last exactly four clock cycles. While a sequence runs, `busy` stalls the core's fetch.

On entry the sequencer clears the global enable and acknowledges the source. It then pushes the resume address onto an external return-address stack and finally loads the program counter with the fixed vector address. On return it pops the stack, sets the global enable and loads the program counter with the popped address. After a return, a hold-off bit keeps the next boundary from taking an interrupt. This guarantees that one main-program instruction executes before any pending request is served. The execute stage raises the boundary strobe only when an instruction, including a multi-cycle one, is complete. As a result, a request that arrives part-way through an instruction waits for that instruction to finish.

Top module: `irq_seq_top`

## Requirements
- R1: After reset the sequencer is idle: `busy`, `irq_ack`, `gie_clr`, `gie_set`, `push_en`, `pop_en` and `pc_load` are all low, and the hold-off bit is clear.
- R2: A request is accepted only in a cycle where `insn_done` is high, the sequencer is idle, `gie_i` is high, the hold-off bit is clear and `reti_dec` is low. A request held high across cycles with `insn_done` low, such as during a multi-cycle instruction, starts nothing.
- R3: One cycle after acceptance (entry cycle 1), `irq_ack` and `gie_clr` are high for exactly one cycle.
- R4: In entry cycle 2, `push_en` is high and `push_data` equals the `pc_cur` value present in the accepting cycle.
- R5: In entry cycle 4, `pc_load` is high with `pc_load_val` equal to the VECTOR parameter. `busy` is high in entry cycles 1 to 4 and low in the cycle after.
- R6: While `gie_i` is low, a request at a boundary is not accepted.
- R7: `reti_dec` with `insn_done` while idle starts a return. In return cycle 1 `pop_en` is high, in return cycle 3 `gie_set` is high, and in return cycle 4 `pc_load` is high with `pc_load_val` equal to the `pop_data` value seen in return cycle 1. `busy` is high in return cycles 1 to 4.
- R8: When `reti_dec`, `insn_done` and an enabled request coincide, the return is started and the request is not acknowledged.
- R9: The end of a return sets the hold-off bit. The next boundary accepts no request and clears the bit, and the boundary after that may accept.
- R10: `insn_done`, `reti_dec`, `irq_req` and `pc_cur` are ignored while `busy` is high. A running sequence completes unchanged and no second sequence starts from them.
- R11: Outside the cycles listed in R3 to R7, all strobes and `busy` are low, and at most one of `push_en`, `pop_en`, `pc_load`, `gie_set` and `irq_ack` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | 1 | Level interrupt request |
| gie_i | input | 1 | Current global interrupt-enable bit |
| insn_done | input | 1 | Instruction boundary from the execute stage |
| reti_dec | input | 1 | Boundary instruction is a return-from-interrupt |
| pc_cur | input | PC_W | Resume address at the boundary |
| pop_data | input | PC_W | Top of the return-address stack |
| irq_ack | output | 1 | Acknowledge pulse to the interrupt source |
| gie_clr | output | 1 | Clear the global enable |
| gie_set | output | 1 | Set the global enable |
| push_en | output | 1 | Push strobe to the return stack |
| push_data | output | PC_W | Address to push |
| pop_en | output | 1 | Pop strobe to the return stack |
| pc_load | output | 1 | Load the program counter |
| pc_load_val | output | PC_W | Value to load into the program counter |
| busy | output | 1 | A sequence is running; stall fetch |

## Verification
The hardest state to reach from the ports is a boundary that arrives with a pending, enabled request while the hold-off bit is set. Reaching it takes a full entry, a return that re-enables interrupts, and then a boundary with the request still held. The stimulus builds exactly that chain. It then offers a second boundary, which must accept. A second hard case is a boundary that carries a return decode and an enabled request together. To get there, the bench raises its modelled enable bit from outside after an entry, so that the return and the request meet at the same boundary.

// File: rtl/irq_seq_pkg.sv
// Package: shared constants and types of the interrupt entry/return sequencer.
// Assumes both sequences have the same fixed length of four cycles.
package irq_seq_pkg;

    localparam int SEQ_LEN = 4;
    localparam int PH_W    = $clog2(SEQ_LEN);

    // phase positions inside a sequence, derived from the length
    localparam logic [PH_W-1:0] PH_FIRST = '0;
    localparam logic [PH_W-1:0] PH_PUSH  = PH_W'(1);
    localparam logic [PH_W-1:0] PH_GSET  = PH_W'(SEQ_LEN - 2);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(SEQ_LEN - 1);

    typedef enum logic [1:0] {
        MD_IDLE   = 2'd0,
        MD_ENTRY  = 2'd1,
        MD_RETURN = 2'd2
    } seq_mode_t;

    typedef struct packed {
        logic ack;
        logic gclr;
        logic gset;
        logic push;
        logic pop;
        logic load;
    } seq_strobe_t;

endpackage

// File: rtl/irq_gate.sv
// Module: acceptance gate and post-return hold-off bit.
// Decides at each instruction boundary whether a return or an interrupt
// entry starts. Assumes insn_done is only meaningful while idle.
module irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic idle,
    input  logic irq_req,
    input  logic gie_i,
    input  logic insn_done,
    input  logic reti_dec,
    input  logic ret_done,
    output logic take_irq,
    output logic take_ret,
    output logic holdoff_q
);

    logic at_boundary;

    // purpose: qualify the boundary strobe with the idle state
    always_comb begin
        at_boundary = idle && insn_done;
    end

    // purpose: a return decode wins over an interrupt at the same boundary
    always_comb begin
        take_ret = at_boundary && reti_dec;
        take_irq = at_boundary && !reti_dec && irq_req && gie_i && !holdoff_q;
    end

    // purpose: hold-off is set by a finished return, cleared by the next boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            holdoff_q <= 1'b0;
        end else if (ret_done) begin
            holdoff_q <= 1'b1;
        end else if (at_boundary) begin
            holdoff_q <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_seq_ctl.sv
// Module: sequence controller for entry and return.
// A mode register and a phase counter step through a fixed-length sequence
// and decode the strobes for each phase. Assumes take_irq and take_ret are
// only raised while idle.
module irq_seq_ctl
    import irq_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take_irq,
    input  logic        take_ret,
    output logic        idle,
    output logic        ret_done,
    output logic        in_entry,
    output seq_strobe_t strb
);

    seq_mode_t       mode_q;
    logic [PH_W-1:0] phase_q;
    logic            last_ph;

    // purpose: flag the final phase of any running sequence
    always_comb begin
        last_ph = (mode_q != MD_IDLE) && (phase_q == PH_LAST);
    end

    // purpose: mode and phase registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MD_IDLE;
            phase_q <= PH_FIRST;
        end else begin
            case (mode_q)
                MD_IDLE: begin
                    phase_q <= PH_FIRST;
                    if (take_ret) begin
                        mode_q <= MD_RETURN;
                    end else if (take_irq) begin
                        mode_q <= MD_ENTRY;
                    end
                end
                default: begin
                    if (last_ph) begin
                        mode_q  <= MD_IDLE;
                        phase_q <= PH_FIRST;
                    end else begin
                        phase_q <= phase_q + PH_W'(1);
                    end
                end
            endcase
        end
    end

    // purpose: status towards the gate and the address path
    always_comb begin
        idle     = (mode_q == MD_IDLE);
        in_entry = (mode_q == MD_ENTRY);
        ret_done = (mode_q == MD_RETURN) && (phase_q == PH_LAST);
    end

    // purpose: decode the strobes for the current phase
    always_comb begin
        strb = '0;
        case (mode_q)
            MD_ENTRY: begin
                strb.ack  = (phase_q == PH_FIRST);
                strb.gclr = (phase_q == PH_FIRST);
                strb.push = (phase_q == PH_PUSH);
                strb.load = (phase_q == PH_LAST);
            end
            MD_RETURN: begin
                strb.pop  = (phase_q == PH_FIRST);
                strb.gset = (phase_q == PH_GSET);
                strb.load = (phase_q == PH_LAST);
            end
            default: strb = '0;
        endcase
    end

endmodule

// File: rtl/irq_addr_path.sv
// Module: address path of the sequencer.
// Captures the resume address at acceptance and the popped address during
// the pop cycle, and selects the value loaded into the program counter.
// Assumes pop_data is valid in the cycle pop_en is high.
module irq_addr_path #(
    parameter int              PC_W   = 9,
    parameter logic [PC_W-1:0] VECTOR = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_irq,
    input  logic            pop_en,
    input  logic            in_entry,
    input  logic [PC_W-1:0] pc_cur,
    input  logic [PC_W-1:0] pop_data,
    output logic [PC_W-1:0] push_data,
    output logic [PC_W-1:0] pc_load_val
);

    logic [PC_W-1:0] resume_q;
    logic [PC_W-1:0] popped_q;

    // purpose: hold the resume address from the accepting boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resume_q <= '0;
        end else if (take_irq) begin
            resume_q <= pc_cur;
        end
    end

    // purpose: hold the address read from the stack during the pop cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            popped_q <= '0;
        end else if (pop_en) begin
            popped_q <= pop_data;
        end
    end

    // purpose: drive the stack write data and the program counter load value
    always_comb begin
        push_data   = resume_q;
        pc_load_val = in_entry ? VECTOR : popped_q;
    end

endmodule

// File: rtl/irq_seq_top.sv
// Module: interrupt entry and return sequencer, top level.
// Connects the acceptance gate, the sequence controller and the address
// path. Assumes the execute stage raises insn_done only when an instruction,
// multi-cycle ones included, has fully completed, and holds off fetch while
// busy is high.
module irq_seq_top #(
    parameter int              PC_W   = 9,
    parameter logic [PC_W-1:0] VECTOR = PC_W'(1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_req,
    input  logic            gie_i,
    input  logic            insn_done,
    input  logic            reti_dec,
    input  logic [PC_W-1:0] pc_cur,
    input  logic [PC_W-1:0] pop_data,
    output logic            irq_ack,
    output logic            gie_clr,
    output logic            gie_set,
    output logic            push_en,
    output logic [PC_W-1:0] push_data,
    output logic            pop_en,
    output logic            pc_load,
    output logic [PC_W-1:0] pc_load_val,
    output logic            busy
);
    import irq_seq_pkg::*;

    logic        idle;
    logic        ret_done;
    logic        in_entry;
    logic        take_irq;
    logic        take_ret;
    logic        holdoff_q;
    seq_strobe_t strb;

    irq_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle      (idle),
        .irq_req   (irq_req),
        .gie_i     (gie_i),
        .insn_done (insn_done),
        .reti_dec  (reti_dec),
        .ret_done  (ret_done),
        .take_irq  (take_irq),
        .take_ret  (take_ret),
        .holdoff_q (holdoff_q)
    );

    irq_seq_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_irq (take_irq),
        .take_ret (take_ret),
        .idle     (idle),
        .ret_done (ret_done),
        .in_entry (in_entry),
        .strb     (strb)
    );

    irq_addr_path #(
        .PC_W   (PC_W),
        .VECTOR (VECTOR)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_irq    (take_irq),
        .pop_en      (strb.pop),
        .in_entry    (in_entry),
        .pc_cur      (pc_cur),
        .pop_data    (pop_data),
        .push_data   (push_data),
        .pc_load_val (pc_load_val)
    );

    // purpose: map the decoded strobes onto the ports
    always_comb begin
        irq_ack = strb.ack;
        gie_clr = strb.gclr;
        gie_set = strb.gset;
        push_en = strb.push;
        pop_en  = strb.pop;
        pc_load = strb.load;
        busy    = !idle;
    end

endmodule

// File: rtl/irq_seq_chk.sv
// Module: property checker for the sequencer, bound to the top level.
// Assumes the default four-cycle sequence length.
module irq_seq_chk #(
    parameter int              PC_W   = 9,
    parameter logic [PC_W-1:0] VECTOR = PC_W'(1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq_req,
    input logic            gie_i,
    input logic            insn_done,
    input logic            reti_dec,
    input logic [PC_W-1:0] pc_cur,
    input logic [PC_W-1:0] pop_data,
    input logic            irq_ack,
    input logic            gie_clr,
    input logic            gie_set,
    input logic            push_en,
    input logic [PC_W-1:0] push_data,
    input logic            pop_en,
    input logic            pc_load,
    input logic [PC_W-1:0] pc_load_val,
    input logic            busy,
    input logic            holdoff_q
);

    AST_ACCEPT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && irq_req && gie_i && !reti_dec && !busy && !holdoff_q) |=> (irq_ack && gie_clr)); // R3

    AST_PUSH_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (push_en && push_data == $past(pc_cur, 2))); // R4

    AST_VECTOR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> ##2 (pc_load && pc_load_val == VECTOR)); // R5

    AST_LOAD_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !busy); // R5

    AST_NO_GIE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!gie_i && !busy) |=> !irq_ack); // R6

    AST_RETURN_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && reti_dec && !busy) |=> pop_en); // R7

    AST_RETURN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> ##2 gie_set ##1 (pc_load && pc_load_val == $past(pop_data, 3))); // R7

    AST_RETURN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && reti_dec && irq_req && !busy) |=> !irq_ack); // R8

    AST_HOLDOFF_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (holdoff_q && insn_done && !busy) |=> !irq_ack); // R9

    AST_SEQ_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pc_load) |=> busy); // R10

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push_en, pop_en, pc_load, gie_set, irq_ack})); // R11

endmodule

bind irq_seq_top irq_seq_chk #(
    .PC_W   (PC_W),
    .VECTOR (VECTOR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .gie_i       (gie_i),
    .insn_done   (insn_done),
    .reti_dec    (reti_dec),
    .pc_cur      (pc_cur),
    .pop_data    (pop_data),
    .irq_ack     (irq_ack),
    .gie_clr     (gie_clr),
    .gie_set     (gie_set),
    .push_en     (push_en),
    .push_data   (push_data),
    .pop_en      (pop_en),
    .pc_load     (pc_load),
    .pc_load_val (pc_load_val),
    .busy        (busy),
    .holdoff_q   (holdoff_q)
);

// File: tb/irq_seq_top_test.sv
// Bench: scoreboard for the interrupt entry and return sequencer.
// Driver tasks queue the expected per-cycle strobe patterns; a monitor
// compares every cycle against the queue (no item means all strobes low).
module irq_seq_top_test;

    localparam int         CLK_PERIOD = 10;
    localparam int         PC_W       = 9;
    localparam logic [8:0] VEC        = 9'h010;

    // strobe vector bit layout: {busy, ack, gclr, push, pop, gset, load}
    localparam int B_PUSH = 3;
    localparam int B_LOAD = 0;

    typedef struct {
        int         cyc;
        logic [6:0] vec;
        logic [8:0] val;
        string      req;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            irq_req;
    logic            gie_q;
    logic            insn_done;
    logic            reti_dec;
    logic [PC_W-1:0] pc_cur;
    logic [PC_W-1:0] pop_data;
    logic            irq_ack, gie_clr, gie_set, push_en, pop_en, pc_load, busy;
    logic [PC_W-1:0] push_data, pc_load_val;
    logic            force_gie;

    int    cyc;
    int    checks;
    int    errors;
    bit    mon_on;
    string idle_tag;
    exp_t  exp_q[$];
    exp_t  it;
    logic [6:0] act;
    logic [8:0] act_val;

    logic [PC_W-1:0] stk [0:3];
    int              sp;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_seq_top #(.PC_W(PC_W), .VECTOR(VEC)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_req     (irq_req),
        .gie_i       (gie_q),
        .insn_done   (insn_done),
        .reti_dec    (reti_dec),
        .pc_cur      (pc_cur),
        .pop_data    (pop_data),
        .irq_ack     (irq_ack),
        .gie_clr     (gie_clr),
        .gie_set     (gie_set),
        .push_en     (push_en),
        .push_data   (push_data),
        .pop_en      (pop_en),
        .pc_load     (pc_load),
        .pc_load_val (pc_load_val),
        .busy        (busy)
    );

    // cycle counter
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // global enable register of the surrounding core
    always @(posedge clk) begin
        if (!rst_n)         gie_q <= 1'b1;
        else if (gie_clr)   gie_q <= 1'b0;
        else if (gie_set)   gie_q <= 1'b1;
        else if (force_gie) gie_q <= 1'b1;
    end

    // return-address stack model
    always @(posedge clk) begin
        if (!rst_n) begin
            sp <= 0;
        end else if (push_en) begin
            stk[sp] <= push_data;
            sp      <= sp + 1;
        end else if (pop_en && sp > 0) begin
            sp <= sp - 1;
        end
    end
    assign pop_data = (sp > 0) ? stk[sp-1] : '0;

    task automatic check(input string req, input bit ok, input logic [6:0] a,
                         input logic [8:0] av, input logic [6:0] e, input logic [8:0] ev);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: cycle %0d strobes %b value %h, expected %b value %h",
                     req, cyc, a, av, e, ev);
        end
    endtask

    // monitor: compare every cycle with the scoreboard
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            act     = {busy, irq_ack, gie_clr, push_en, pop_en, gie_set, pc_load};
            act_val = push_en ? push_data : pc_load_val;
            if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
                it = exp_q.pop_front();
                check(it.req,
                      (act == it.vec)
                      && (!it.vec[B_PUSH] || push_data == it.val)
                      && (!it.vec[B_LOAD] || pc_load_val == it.val),
                      act, act_val, it.vec, it.val);
            end else begin
                check(idle_tag, act == 7'b0, act, act_val, 7'b0, 9'h0);
            end
        end
    end

    // driver: present one boundary cycle; kind 0 none, 1 entry, 2 return
    task automatic step(input bit ins, input bit ret, input bit rq,
                        input logic [8:0] pc, input int kind,
                        input logic [8:0] v, input string tg);
        int a;
        a         = cyc;
        insn_done = ins;
        reti_dec  = ret;
        irq_req   = rq;
        pc_cur    = pc;
        if (kind == 1) begin
            exp_q.push_back('{a+1, 7'b1110000, 9'h0, tg});
            exp_q.push_back('{a+2, 7'b1001000, pc,   "R4"});
            exp_q.push_back('{a+3, 7'b1000000, 9'h0, "R5"});
            exp_q.push_back('{a+4, 7'b1000001, VEC,  "R5"});
        end else if (kind == 2) begin
            exp_q.push_back('{a+1, 7'b1000100, 9'h0, tg});
            exp_q.push_back('{a+2, 7'b1000000, 9'h0, "R7"});
            exp_q.push_back('{a+3, 7'b1000010, 9'h0, "R7"});
            exp_q.push_back('{a+4, 7'b1000001, v,    "R7"});
        end
        @(posedge clk); #1;
        insn_done = 1'b0;
        reti_dec  = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        checks = 0; errors = 0; mon_on = 0; idle_tag = "R11";
        rst_n = 0; irq_req = 0; insn_done = 0; reti_dec = 0; pc_cur = '0;
        force_gie = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1", {busy, irq_ack, gie_clr, push_en, pop_en, gie_set, pc_load} == 7'b0,
              {busy, irq_ack, gie_clr, push_en, pop_en, gie_set, pc_load}, 9'h0, 7'b0, 9'h0);
        mon_on = 1;
        @(posedge clk); #1;

        // R2: request held while a multi-cycle instruction runs (no boundary)
        idle_tag = "R2";
        irq_req  = 1;
        wait_cyc(5);
        step(1, 0, 1, 9'h0A5, 1, 9'h0, "R3");
        wait_cyc(5);

        // R6: enable is now clear, boundary with a request is refused
        idle_tag = "R6";
        step(1, 0, 1, 9'h0B0, 0, 9'h0, "R6");
        wait_cyc(2);

        // R7: return restores the pushed address and sets the enable
        idle_tag = "R11";
        step(1, 1, 1, 9'h0B1, 2, 9'h0A5, "R7");
        wait_cyc(5);

        // R9: first boundary after the return is held off, the next accepts
        idle_tag = "R9";
        step(1, 0, 1, 9'h0A6, 0, 9'h0, "R9");
        wait_cyc(1);
        step(1, 0, 1, 9'h0A7, 1, 9'h0, "R9");
        // R10: boundary, return decode and address changes during the entry
        idle_tag  = "R10";
        insn_done = 1; reti_dec = 1; pc_cur = 9'h155;
        wait_cyc(3);
        insn_done = 0; reti_dec = 0; irq_req = 0;
        wait_cyc(3);

        // R7: second return pops the address captured at the R9 boundary
        idle_tag = "R11";
        step(1, 1, 0, 9'h0C0, 2, 9'h0A7, "R7");
        wait_cyc(5);

        // boundary without a request consumes the hold-off, then the top address enters
        step(1, 0, 0, 9'h0C1, 0, 9'h0, "R11");
        wait_cyc(1);
        step(1, 0, 1, 9'h1FF, 1, 9'h0, "R3");
        irq_req = 0;
        wait_cyc(5);

        // R8: enable forced back on, then return and request meet at one boundary
        force_gie = 1;
        wait_cyc(1);
        force_gie = 0;
        wait_cyc(1);
        idle_tag = "R8";
        step(1, 1, 1, 9'h0C2, 2, 9'h1FF, "R8");
        wait_cyc(5);
        irq_req = 0;
        wait_cyc(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule